// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 pins of one GPIO bank, arranged as four ports of eight pins, and turns pin activity into a single bank interrupt. Each pin carries its own trigger setting: rising edge, falling edge, either edge, level high or level low. When a pin meets its trigger condition, its status bit is set and stays set until software clears it. Per-pin enable bits decide which status bits may raise the bank interrupt. The interrupt line is the OR, over all four ports, of status AND enable.

Pin values arrive already synchronised to the block clock. Software reaches the per-port registers through a simple single-cycle write bus with combinational read data. The register nibble sits in address bits [7:4] and the port number in address bits [3:2]. Enable and trigger settings can each be written whole. They can also be written through masked aliases, which change only the selected pins and avoid a read-modify-write sequence. Status bits are cleared by writing ones to a clear register. While a level trigger is active, its status bit is set again every cycle, so a clear only takes effect once the level has gone away.

Top module: `gpint_bank`

## Requirements
- R1: After synchronous reset, every port's enable register reads 0 and `bank_irq` is low.
- R2: Trigger bits {both, edge, polarity} = {0,1,1} (code 0x000101 at pin n) set the status bit on a 0-to-1 pin change only. A 1-to-0 change leaves it clear.
- R3: Code {0,1,0} (0x000100 at pin n) sets the status bit on a 1-to-0 change only.
- R4: Code {1,1,0} (0x010100 at pin n) sets the status bit on either change.
- R5: Code {0,0,1} (0x000001 at pin n) sets the status bit in every cycle the pin is high. A clear issued while the pin is still high leaves the bit set. A clear issued after the pin goes low clears it.
- R6: Code {0,0,0} sets the status bit in every cycle the pin is low. A high pin does not set it.
- R7: Writing to the clear register (nibble 0x7) clears each status bit whose data bit is 1. Zero bits leave status unchanged. A trigger event in the same cycle as a clear of that pin leaves the bit set.
- R8: `bank_irq` is high exactly when some status bit and its enable bit are both 1, in any port. A status bit latches whether or not its pin is enabled.
- R9: A write to the masked enable alias (nibble 0xD) replaces the enable bit of each pin n whose select bit data[8+n] is 1 with data[n]. Other pins keep their enable bits.
- R10: A write to the masked trigger alias (nibble 0xE) replaces the three trigger bits (n, 8+n, 16+n) of each pin n whose select bit data[24+n] is 1 with the same data bits. Other pins keep their trigger bits.
- R11: Port p's registers are at address {nibble, p[1:0], 2'b00}. The trigger word keeps polarity in bits 7:0, edge select in bits 15:8 and both-edge select in bits 23:16, and status and enable sit in bits 7:0.
- R12: A new edge that arrives after a status bit has been cleared sets the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 32 | Synchronised pin values, pin 8p+n is port p pin n |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register address: nibble in [7:4], port in [3:2] |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bank_irq | output | 1 | Bank interrupt |

## Verification
The bench drives each trigger code on a different port and pin, and checks that the opposite edge is ignored. A design that mixed up the polarity or edge-select bits would latch on the wrong transition. It clears a level-high pin while the level is still active, and expects the bit to stay set. It also lands a clear in the same cycle as a rising edge. A design with clear-over-set priority would lose that event, and one that does not re-set level status every cycle would drop an active level. The masked aliases are checked by reading back neighbouring pins, since a write that ignored the select byte would corrupt them. The interrupt is checked with status present but its enable off, and with an enable on a different port.

// File: rtl/gpint_pkg.sv
// Package: shared register selects and trigger decode for the GPIO bank
// interrupt detector. Assumes a pin's history is the value it had one
// clock earlier.
package gpint_pkg;

    // Address field positions: register nibble and port number.
    localparam int SEL_LSB  = 4;
    localparam int SEL_W    = 4;
    localparam int PORT_LSB = 2;
    localparam int PORT_W   = 2;

    // Register nibbles (address bits [7:4]).
    typedef enum logic [SEL_W-1:0] {
        RSEL_STATUS     = 4'h4,
        RSEL_ENABLE     = 4'h5,
        RSEL_TRIG       = 4'h6,
        RSEL_CLEAR      = 4'h7,
        RSEL_ENABLE_MSK = 4'hD,
        RSEL_TRIG_MSK   = 4'hE
    } reg_sel_e;

    // One pin's trigger setting, gathered from the three bit planes.
    typedef struct packed {
        logic both;
        logic edge_mode;
        logic polarity;
    } trig_cfg_t;

    // Decide whether a pin meets its trigger condition this cycle.
    function automatic logic pin_event(input trig_cfg_t cfg,
                                       input logic cur,
                                       input logic last);
        logic rise;
        logic fall;
        rise = cur & ~last;
        fall = ~cur & last;
        if (cfg.edge_mode) begin
            if (cfg.both) return rise | fall;
            return cfg.polarity ? rise : fall;
        end
        return cfg.polarity ? cur : ~cur;
    endfunction

endpackage

// File: rtl/gpint_port_regs.sv
// Module: enable and trigger-type registers of one port. Supports whole
// writes and masked writes. A masked write carries a select field above
// the value field. Assumes 4*PINS <= DATA_W. Only one write strobe is
// active per cycle.
module gpint_port_regs #(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_enable,
    input  logic                wr_enable_msk,
    input  logic                wr_trig,
    input  logic                wr_trig_msk,
    input  logic [DATA_W-1:0]   wdata,
    output logic [PINS-1:0]     enable,
    output logic [3*PINS-1:0]   trig
);
    localparam int TRIG_W = 3 * PINS;

    logic [PINS-1:0]   en_val;
    logic [PINS-1:0]   en_sel;
    logic [TRIG_W-1:0] tr_val;
    logic [PINS-1:0]   tr_sel;
    logic [TRIG_W-1:0] tr_sel_wide;

    // Split write data into value and select fields.
    assign en_val      = wdata[PINS-1:0];
    assign en_sel      = wdata[2*PINS-1:PINS];
    assign tr_val      = wdata[TRIG_W-1:0];
    assign tr_sel      = wdata[4*PINS-1:3*PINS];
    assign tr_sel_wide = {3{tr_sel}};

    // Enable register: whole or per-pin masked update, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (wr_enable) begin
            enable <= en_val;
        end else if (wr_enable_msk) begin
            enable <= (enable & ~en_sel) | (en_val & en_sel);
        end
    end

    // Trigger word: whole or per-pin masked update of all three bit planes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig <= '0;
        end else if (wr_trig) begin
            trig <= tr_val;
        end else if (wr_trig_msk) begin
            trig <= (trig & ~tr_sel_wide) | (tr_val & tr_sel_wide);
        end
    end

endmodule

// File: rtl/gpint_pin_detect.sv
// Module: per-pin trigger detector for one port. Compares each pin with
// its value one clock earlier. Assumes pins are already synchronised. No
// event is reported in the first cycle after reset, while the history is
// loaded.
module gpint_pin_detect
    import gpint_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin,
    input  logic [3*PINS-1:0] trig,
    output logic [PINS-1:0]   evt
);
    logic [PINS-1:0] last;
    logic            primed;

    // Pin history, one clock deep; needs no reset value.
    always_ff @(posedge clk) begin
        last <= pin;
    end

    // History-valid flag, low during reset and its first following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        trig_cfg_t cfg;
        // Gather this pin's three trigger bits from the port word.
        assign cfg = '{both:      trig[2*PINS+n],
                       edge_mode: trig[PINS+n],
                       polarity:  trig[n]};
        // Report the event once history is valid.
        assign evt[n] = primed & pin_event(cfg, pin[n], last[n]);
    end

endmodule

// File: rtl/gpint_port_status.sv
// Module: status latch of one port. A bit is set by a trigger event and
// cleared by a one in the clear vector. Set wins over clear in the same
// cycle. Assumes the clear vector is a single-cycle pulse.
module gpint_port_status #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] evt,
    input  logic [PINS-1:0] clr,
    output logic [PINS-1:0] sta
);
    // Latch events and apply write-one clears, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sta <= '0;
        else        sta <= (sta & ~clr) | evt;
    end

endmodule

// File: rtl/gpint_bank.sv
// Module: GPIO bank interrupt detector top. Decodes the register bus,
// holds per-port enable, trigger and status state, and drives one bank
// interrupt. Assumes PORTS <= 4 and PINS_PER_PORT <= 8, so the address
// and masked-write fields fit. Read data is combinational on bus_addr.
module gpint_bank
    import gpint_pkg::*;
#(
    parameter int PORTS         = 4,
    parameter int PINS_PER_PORT = 8,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PORTS*PINS_PER_PORT-1:0]   pin_in,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic                             bank_irq
);
    localparam int PP     = PINS_PER_PORT;
    localparam int NPINS  = PORTS * PP;
    localparam int TRIG_W = 3 * PP;
    localparam int DEC_W  = SEL_LSB + SEL_W;

    logic [SEL_W-1:0]        reg_nib;
    logic [PORT_W-1:0]       port_fld;
    logic                    addr_ok;
    logic [NPINS-1:0]        sta_all;
    logic [NPINS-1:0]        enb_all;
    logic [NPINS-1:0]        evt_all;
    logic [NPINS-1:0]        clr_all;
    logic [NPINS-1:0]        edge_all;
    logic [PORTS*TRIG_W-1:0] trig_flat;

    // Address fields and validity: word aligned, in range, existing port.
    assign reg_nib  = bus_addr[SEL_LSB +: SEL_W];
    assign port_fld = bus_addr[PORT_LSB +: PORT_W];
    assign addr_ok  = (bus_addr[PORT_LSB-1:0] == '0)
                   && ((bus_addr >> DEC_W) == '0)
                   && (int'(port_fld) < PORTS);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic wr_p;

        // Write strobe for this port.
        assign wr_p = bus_wr & addr_ok & (port_fld == PORT_W'(p));

        gpint_port_regs #(
            .PINS   (PP),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_enable     (wr_p && (reg_nib == RSEL_ENABLE)),
            .wr_enable_msk (wr_p && (reg_nib == RSEL_ENABLE_MSK)),
            .wr_trig       (wr_p && (reg_nib == RSEL_TRIG)),
            .wr_trig_msk   (wr_p && (reg_nib == RSEL_TRIG_MSK)),
            .wdata         (bus_wdata),
            .enable        (enb_all[p*PP +: PP]),
            .trig          (trig_flat[p*TRIG_W +: TRIG_W])
        );

        gpint_pin_detect #(
            .PINS (PP)
        ) u_detect (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[p*PP +: PP]),
            .trig  (trig_flat[p*TRIG_W +: TRIG_W]),
            .evt   (evt_all[p*PP +: PP])
        );

        // Write-one clear pulse for this port's status bits.
        assign clr_all[p*PP +: PP] = (wr_p && (reg_nib == RSEL_CLEAR))
                                   ? bus_wdata[PP-1:0] : '0;

        // Edge-select plane, brought out for the checker.
        assign edge_all[p*PP +: PP] = trig_flat[p*TRIG_W + PP +: PP];

        gpint_port_status #(
            .PINS (PP)
        ) u_status (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_all[p*PP +: PP]),
            .clr   (clr_all[p*PP +: PP]),
            .sta   (sta_all[p*PP +: PP])
        );
    end

    // Read mux: the addressed port's register, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (reg_nib)
                RSEL_STATUS:
                    bus_rdata[PP-1:0] = sta_all[port_fld*PP +: PP];
                RSEL_ENABLE, RSEL_ENABLE_MSK:
                    bus_rdata[PP-1:0] = enb_all[port_fld*PP +: PP];
                RSEL_TRIG, RSEL_TRIG_MSK:
                    bus_rdata[TRIG_W-1:0] = trig_flat[port_fld*TRIG_W +: TRIG_W];
                default:
                    bus_rdata = '0;
            endcase
        end
    end

    // Bank interrupt: any enabled status bit in any port.
    assign bank_irq = |(sta_all & enb_all);

endmodule

// File: rtl/gpint_bank_checker.sv
// Module: protocol checker for gpint_bank, attached with bind. Checks reset
// quietness, set and clear behaviour of status, and edge-trigger sanity.
module gpint_bank_checker #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bank_irq,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] sta,
    input logic [NPINS-1:0] enb,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] edge_sel
);
    AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !bank_irq);                                      // R1

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (enb != '0));                                         // R8

    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~sta & $past(evt)) == '0));                     // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((sta & $past(clr & ~evt)) == '0));               // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((sta ^ $past(sta)) & ~$past(evt | clr)) == '0)); // R8

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((evt & edge_sel & ~(pin_in ^ $past(pin_in))) == '0)); // R2

endmodule

bind gpint_bank gpint_bank_checker u_gpint_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_irq (bank_irq),
    .pin_in   (pin_in),
    .sta      (sta_all),
    .enb      (enb_all),
    .evt      (evt_all),
    .clr      (clr_all),
    .edge_sel (edge_all)
);

// File: tb/gpint_bank_bench.sv
// Directed bench for gpint_bank: one task per scenario. Inputs change on
// the falling clock edge, and results are sampled there too.
module gpint_bank_bench;

    logic        clk;
    logic        rst_n;
    logic [31:0] pin_in;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bank_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    gpint_bank u_gpint_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bank_irq  (bank_irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    localparam logic [3:0] N_STA = 4'h4, N_ENB = 4'h5, N_TRG = 4'h6,
                           N_CLR = 4'h7, N_ENBM = 4'hD, N_TRGM = 4'hE;

    function automatic logic [7:0] ra(input logic [3:0] nib, input int port);
        return {nib, 2'(port), 2'b00};
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // All ports rising-edge, pins low, status clear, enables off.
    task automatic init_all();
        pin_in = '0;
        for (int p = 0; p < 4; p++) wr(ra(N_TRG, p), 32'h0000FFFF);
        for (int p = 0; p < 4; p++) wr(ra(N_ENB, p), 32'h0);
        for (int p = 0; p < 4; p++) wr(ra(N_CLR, p), 32'hFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, bank_irq}, 32'h0);
        for (int p = 0; p < 4; p++) begin
            rd(ra(N_ENB, p), d);
            check("R1 enable after reset", d, 32'h0);
        end
    endtask

    task automatic t_rising();
        logic [31:0] d;
        init_all();
        pin_in[3] = 1'b1; tick();
        rd(ra(N_STA, 0), d); check("R2 rise sets", d, 32'h08);
        wr(ra(N_CLR, 0), 32'h08);
        pin_in[3] = 1'b0; tick(); tick();
        rd(ra(N_STA, 0), d); check("R2 fall ignored", d, 32'h00);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        init_all();
        wr(ra(N_TRGM, 1), 32'h2000_2000);
        rd(ra(N_TRG, 1), d); check("R10 masked trig readback", d, 32'h0000FFDF);
        pin_in[13] = 1'b1; tick(); tick();
        rd(ra(N_STA, 1), d); check("R3 rise ignored", d, 32'h00);
        pin_in[13] = 1'b0; tick();
        rd(ra(N_STA, 1), d); check("R3 R11 fall sets port1", d, 32'h20);
    endtask

    task automatic t_both();
        logic [31:0] d;
        init_all();
        wr(ra(N_TRG, 2), 32'h0001FFFE);
        pin_in[16] = 1'b1; tick();
        rd(ra(N_STA, 2), d); check("R4 rise sets", d, 32'h01);
        wr(ra(N_CLR, 2), 32'h01);
        rd(ra(N_STA, 2), d); check("R4 cleared", d, 32'h00);
        pin_in[16] = 1'b0; tick();
        rd(ra(N_STA, 2), d); check("R4 fall sets", d, 32'h01);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        init_all();
        wr(ra(N_TRG, 3), 32'h00007FFF);
        tick();
        rd(ra(N_STA, 3), d); check("R5 low pin no status", d, 32'h00);
        pin_in[31] = 1'b1; tick();
        rd(ra(N_STA, 3), d); check("R5 high sets", d, 32'h80);
        wr(ra(N_CLR, 3), 32'h80);
        rd(ra(N_STA, 3), d); check("R5 clear while high holds", d, 32'h80);
        pin_in[31] = 1'b0; tick();
        wr(ra(N_CLR, 3), 32'h80);
        rd(ra(N_STA, 3), d); check("R5 clear after low", d, 32'h00);
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        init_all();
        wr(ra(N_TRG, 0), 32'h0000FDFD);
        tick();
        rd(ra(N_STA, 0), d); check("R6 low sets", d, 32'h02);
        pin_in[1] = 1'b1; tick();
        wr(ra(N_CLR, 0), 32'h02);
        tick();
        rd(ra(N_STA, 0), d); check("R6 high no status", d, 32'h00);
        pin_in[1] = 1'b0; tick();
        rd(ra(N_STA, 0), d); check("R6 low sets again", d, 32'h02);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        init_all();
        pin_in[8] = 1'b1; pin_in[10] = 1'b1; tick();
        rd(ra(N_STA, 1), d); check("R7 two set", d, 32'h05);
        wr(ra(N_CLR, 1), 32'h00);
        rd(ra(N_STA, 1), d); check("R7 zero write no effect", d, 32'h05);
        wr(ra(N_CLR, 1), 32'h01);
        rd(ra(N_STA, 1), d); check("R7 one bit cleared", d, 32'h04);
        pin_in[8] = 1'b0; tick();
        @(negedge clk);
        pin_in[8] = 1'b1;
        bus_wr = 1'b1; bus_addr = ra(N_CLR, 1); bus_wdata = 32'h01;
        tick();
        bus_wr = 1'b0;
        rd(ra(N_STA, 1), d); check("R7 set wins over clear", d, 32'h05);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        init_all();
        pin_in[20] = 1'b1; tick();
        check("R8 no irq while disabled", {31'b0, bank_irq}, 32'h0);
        rd(ra(N_STA, 2), d); check("R8 status latched disabled", d, 32'h10);
        wr(ra(N_ENB, 2), 32'h10);
        check("R8 irq when enabled", {31'b0, bank_irq}, 32'h1);
        wr(ra(N_ENB, 2), 32'hEF);
        wr(ra(N_ENB, 3), 32'h10);
        check("R8 other port enable no irq", {31'b0, bank_irq}, 32'h0);
        wr(ra(N_ENBM, 2), 32'h1010);
        rd(ra(N_ENB, 2), d); check("R9 masked set bit", d, 32'hFF);
        check("R8 irq via masked enable", {31'b0, bank_irq}, 32'h1);
        wr(ra(N_CLR, 2), 32'h10);
        check("R8 irq drops on clear", {31'b0, bank_irq}, 32'h0);
    endtask

    task automatic t_masked_enable();
        logic [31:0] d;
        init_all();
        wr(ra(N_ENB, 1), 32'hF0);
        wr(ra(N_ENBM, 1), 32'h0F05);
        rd(ra(N_ENB, 1), d); check("R9 masked low nibble", d, 32'hF5);
        wr(ra(N_ENBM, 1), 32'h8000);
        rd(ra(N_ENB, 1), d); check("R9 masked clear bit7", d, 32'h75);
    endtask

    task automatic t_relatch();
        logic [31:0] d;
        init_all();
        wr(ra(N_ENB, 0), 32'h40);
        pin_in[6] = 1'b1; tick();
        wr(ra(N_CLR, 0), 32'h40);
        rd(ra(N_STA, 0), d); check("R12 cleared", d, 32'h00);
        pin_in[6] = 1'b0; tick();
        pin_in[6] = 1'b1; tick();
        rd(ra(N_STA, 0), d); check("R12 new edge sets again", d, 32'h40);
        check("R12 irq again", {31'b0, bank_irq}, 32'h1);
    endtask

    initial begin
        rst_n = 1'b0; pin_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_level_low();
        t_clear();
        t_irq();
        t_masked_enable();
        t_relatch();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule